// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt events raised by the channels of a multi-channel DMA engine and reduces them to one interrupt line. Each channel can raise four kinds of event: end of a whole descriptor chain, end of a single descriptor node that asked for notification, and two separate error kinds. Every kind has its own bank of per-channel sticky latches, its own enable mask, and its own masked view. A summary word shows, per channel, whether anything enabled is waiting, so the service routine can scan it from the lowest bit upward.

Software reaches the block through a simple register port with a write strobe, a read strobe, a byte address and a data word. Read data comes back one cycle after the read strobe, together with a valid flag. The latches are cleared by writing ones to them. The per-channel event inputs are one-cycle pulses coming from the channel engines.

The read port is run by a two-state machine. In state RD_IDLE no response is pending. The transition RD_IDLE to RD_RESP is taken when the read strobe is high. The transition RD_RESP to RD_RESP is taken when another read strobe arrives while a response is being presented. The transition RD_RESP to RD_IDLE is taken when no read strobe is present. The valid flag is high exactly in RD_RESP.

Top module: `dmairq_aggr`

## Requirements
- R1: After reset every latch and every mask reads zero, the interrupt line is low and no read response is valid.
- R2: A pulse on a channel's event input sets that channel's bit in the latch of that event kind and the bit stays set until cleared; the latches read at byte offsets 0x600 (chain end), 0x608 (node end), 0x610 (error one) and 0x618 (error two), channel n in bit n.
- R3: The masks sit at 0x18 (chain end), 0x1C (node end), 0x20 (error one) and 0x24 (error two) and read back as written; a mask bit of 1 enables that channel, and the masked views at 0x04, 0x08, 0x0C and 0x10 (same kind order) read latch AND mask.
- R4: A write to a latch offset clears exactly the bits written as 1 and leaves bits written as 0 untouched.
- R5: When an event pulse and a clearing write hit the same latch bit in the same cycle, the bit stays set.
- R6: The summary word at 0x00 has bit n set when any masked view has bit n set.
- R7: Chain-end and node-end events of the same channel are latched, masked and cleared independently of each other.
- R8: The interrupt line is the OR of all masked bits of all kinds and channels, and follows a latch or mask change in the cycle after the causing edge.
- R9: Writes to 0x00 through 0x10 change nothing, reads of any unmapped offset return zero, and bits at and above the channel count always read zero.
- R10: Read data and the valid flag appear in the cycle after the read strobe and reflect the state before that strobe's clock edge; the valid flag is low in any cycle not following a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_chain_i | input | 16 | Per-channel chain-end event pulses |
| evt_node_i | input | 16 | Per-channel node-end event pulses |
| evt_err1_i | input | 16 | Per-channel error kind one pulses |
| evt_err2_i | input | 16 | Per-channel error kind two pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| reg_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The bench aims at a clear and a new event landing on the same bit in one cycle; a design that lets the clear win would lose that event and the latch would read zero. It clears a chain-end bit while a node-end bit of the same channel is pending, which catches a design that shares one latch or one clear path between the two kinds. Partial clears with mixed ones and zeros catch a latch that is overwritten instead of cleared bit by bit, and writes aimed at the read-only status words catch a decoder that lets them alias onto a mask or latch. Masked-off events must leave the interrupt line low, which exposes a line driven from the raw latches.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        CLS_CHAIN = 2'd0,
        CLS_NODE  = 2'd1,
        CLS_ERRA  = 2'd2,
        CLS_ERRB  = 2'd3
    } evt_cls_e;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_SUMMARY = 3'd1,
        SEL_STATUS  = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_RAW     = 3'd4
    } rd_sel_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    typedef struct packed {
        rd_sel_e  sel;
        evt_cls_e cls;
    } reg_hit_t;

    localparam logic [11:0] OFS_SUMMARY = 12'h000;
    localparam logic [11:0] OFS_STAT0   = 12'h004;
    localparam logic [11:0] OFS_MASK0   = 12'h018;
    localparam logic [11:0] OFS_RAW0    = 12'h600;

endpackage

// File: rtl/dmairq_addr_decode.sv
module dmairq_addr_decode
    import dmairq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_hit_t          hit_o
);

    always_comb begin
        hit_o.sel = SEL_NONE;
        hit_o.cls = CLS_CHAIN;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (addr_i == ADDR_W'(OFS_STAT0 + 12'(4 * c))) begin
                hit_o.sel = SEL_STATUS;
                hit_o.cls = evt_cls_e'(c);
            end
            if (addr_i == ADDR_W'(OFS_MASK0 + 12'(4 * c))) begin
                hit_o.sel = SEL_MASK;
                hit_o.cls = evt_cls_e'(c);
            end
            if (addr_i == ADDR_W'(OFS_RAW0 + 12'(8 * c))) begin
                hit_o.sel = SEL_RAW;
                hit_o.cls = evt_cls_e'(c);
            end
        end
        if (addr_i == ADDR_W'(OFS_SUMMARY)) begin
            hit_o.sel = SEL_SUMMARY;
            hit_o.cls = CLS_CHAIN;
        end
    end

endmodule

// File: rtl/dmairq_class_bank.sv
module dmairq_class_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] masked_o
);

    logic [N-1:0] raw_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_we_i ? wdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | evt_i;
            if (mask_we_i) begin
                mask_q <= wdata_i;
            end
        end
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;

endmodule

// File: rtl/dmairq_aggr.sv
module dmairq_aggr
    import dmairq_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_chain_i,
    input  logic [N-1:0]      evt_node_i,
    input  logic [N-1:0]      evt_err1_i,
    input  logic [N-1:0]      evt_err2_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              reg_rvalid_o,
    output logic              irq_o
);

    localparam int PAD_W = DATA_W - N;

    logic [NUM_CLS-1:0][N-1:0] evt_bus;
    logic [NUM_CLS-1:0][N-1:0] raw_q;
    logic [NUM_CLS-1:0][N-1:0] mask_q;
    logic [NUM_CLS-1:0][N-1:0] masked;
    logic [N-1:0]              summary;
    logic [N-1:0]              rd_word;
    logic [DATA_W-1:0]         rdata_q;
    reg_hit_t                  hit;
    rd_state_e                 state_q;
    rd_state_e                 state_d;
    logic                      unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:N];

    assign evt_bus[CLS_CHAIN] = evt_chain_i;
    assign evt_bus[CLS_NODE]  = evt_node_i;
    assign evt_bus[CLS_ERRA]  = evt_err1_i;
    assign evt_bus[CLS_ERRB]  = evt_err2_i;

    dmairq_addr_decode #(
        .ADDR_W (ADDR_W)
    ) dec_i (
        .addr_i (reg_addr_i),
        .hit_o  (hit)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_bank
        logic clr_we;
        logic mask_we;
        assign clr_we  = reg_wr_i && (hit.sel == SEL_RAW)  && (hit.cls == evt_cls_e'(c));
        assign mask_we = reg_wr_i && (hit.sel == SEL_MASK) && (hit.cls == evt_cls_e'(c));

        dmairq_class_bank #(
            .N (N)
        ) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_bus[c]),
            .clr_we_i  (clr_we),
            .mask_we_i (mask_we),
            .wdata_i   (reg_wdata_i[N-1:0]),
            .raw_o     (raw_q[c]),
            .mask_o    (mask_q[c]),
            .masked_o  (masked[c])
        );
    end

    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            summary = summary | masked[c];
        end
    end

    assign irq_o = |summary;

    always_comb begin
        unique case (hit.sel)
            SEL_SUMMARY: rd_word = summary;
            SEL_STATUS:  rd_word = masked[hit.cls];
            SEL_MASK:    rd_word = mask_q[hit.cls];
            SEL_RAW:     rd_word = raw_q[hit.cls];
            default:     rd_word = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = reg_rd_i ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = reg_rd_i ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd_i) begin
            rdata_q <= {{PAD_W{1'b0}}, rd_word};
        end
    end

    always_comb begin
        reg_rvalid_o = (state_q == RD_RESP);
        reg_rdata_o  = reg_rvalid_o ? rdata_q : '0;
    end

endmodule

// File: rtl/dmairq_aggr_chk.sv
module dmairq_aggr_chk #(
    parameter int N      = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N-1:0]        evt_chain_i,
    input logic [N-1:0]        evt_err2_i,
    input logic                reg_wr_i,
    input logic                reg_rd_i,
    input logic [ADDR_W-1:0]   reg_addr_i,
    input logic [DATA_W-1:0]   reg_rdata_o,
    input logic                reg_rvalid_o,
    input logic                irq_o,
    input logic [4*N-1:0]      raw_flat,
    input logic [4*N-1:0]      mask_flat
);

    logic addr_known;
    always_comb begin
        addr_known = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (reg_addr_i == ADDR_W'(4 * k)) addr_known = 1'b1;
        end
        for (int k = 0; k < 4; k++) begin
            if (reg_addr_i == ADDR_W'(12'h018 + 4 * k)) addr_known = 1'b1;
            if (reg_addr_i == ADDR_W'(12'h600 + 8 * k)) addr_known = 1'b1;
        end
    end

    p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_i |=> reg_rvalid_o);

    p_rvalid_needs_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid_o |-> $past(reg_rd_i));

    p_chain_evt_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_chain_i != '0) |=> ((raw_flat[N-1:0] & $past(evt_chain_i)) == $past(evt_chain_i)));

    p_evt_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_err2_i != '0 && reg_wr_i) |=> ((raw_flat[4*N-1:3*N] & $past(evt_err2_i)) == $past(evt_err2_i)));

    p_raw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_i && evt_chain_i == '0) |=> $stable(raw_flat[N-1:0]));

    p_masked_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_flat == '0) |-> !irq_o);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !addr_known) |=> (reg_rdata_o == '0));

endmodule

bind dmairq_aggr dmairq_aggr_chk #(
    .N      (N),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_chain_i  (evt_chain_i),
    .evt_err2_i   (evt_err2_i),
    .reg_wr_i     (reg_wr_i),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .reg_rdata_o  (reg_rdata_o),
    .reg_rvalid_o (reg_rvalid_o),
    .irq_o        (irq_o),
    .raw_flat     (raw_q),
    .mask_flat    (mask_q)
);

// File: tb/dmairq_aggr_tb_top.sv
`timescale 1ns/1ps
module dmairq_aggr_tb_top;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt_chain = '0, evt_node = '0, evt_err1 = '0, evt_err2 = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [N-1:0] m_raw[4];
    logic [N-1:0] m_mask[4];

    always #2 clk = ~clk;

    dmairq_aggr dut_i (
        .clk (clk), .rst_n (rst_n),
        .evt_chain_i (evt_chain), .evt_node_i (evt_node),
        .evt_err1_i (evt_err1), .evt_err2_i (evt_err2),
        .reg_wr_i (wr), .reg_rd_i (rd), .reg_addr_i (addr),
        .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .reg_rvalid_o (rvalid), .irq_o (irq)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [N-1:0] s;
        s = '0;
        for (int c = 0; c < 4; c++) s |= m_raw[c] & m_mask[c];
        if (a == 12'h000) return {16'h0, s};
        for (int c = 0; c < 4; c++) begin
            if (a == 12'(12'h004 + 4 * c)) return {16'h0, m_raw[c] & m_mask[c]};
            if (a == 12'(12'h018 + 4 * c)) return {16'h0, m_mask[c]};
            if (a == 12'(12'h600 + 8 * c)) return {16'h0, m_raw[c]};
        end
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a read response is presented
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_read(input logic [11:0] a, input string tag);
        @(negedge clk);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        for (int c = 0; c < 4; c++) begin
            if (a == 12'(12'h018 + 4 * c)) m_mask[c] = d[N-1:0];
            if (a == 12'(12'h600 + 8 * c)) m_raw[c] &= ~d[N-1:0];
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic pulse(input int cls, input logic [N-1:0] bits);
        @(negedge clk);
        case (cls)
            0: evt_chain = bits;
            1: evt_node = bits;
            2: evt_err1 = bits;
            default: evt_err2 = bits;
        endcase
        @(negedge clk);
        evt_chain = '0; evt_node = '0; evt_err1 = '0; evt_err2 = '0;
        m_raw[cls] |= bits;
    endtask

    initial begin
        #200000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_raw[c] = '0; m_mask[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        check("R1 rvalid after reset", {31'h0, rvalid}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            do_read(12'(12'h600 + 8 * c), "R1 raw reset");
            do_read(12'(12'h018 + 4 * c), "R1 mask reset");
        end

        // R2: events latch while masked; interrupt stays low
        pulse(0, 16'h0005);
        check("R8 masked event keeps irq low", {31'h0, irq}, 32'h0);
        do_read(12'h600, "R2 chain raw");
        pulse(2, 16'h8000);
        do_read(12'h610, "R2 err1 raw");
        do_read(12'h00C, "R3 err1 status masked off");

        // R3/R8: unmask chain class
        do_write(12'h018, 32'hFFFF_FFFF);
        check("R8 irq after unmask", {31'h0, irq}, 32'h1);
        do_read(12'h018, "R9 mask upper bits zero");
        do_read(12'h004, "R3 chain status");
        do_read(12'h000, "R6 summary");

        // R4: partial clear
        do_write(12'h600, 32'h0000_0001);
        do_read(12'h600, "R4 partial clear");

        // R7: chain and node on the same channel
        pulse(1, 16'h0004);
        do_write(12'h01C, 32'h0000_0004);
        do_read(12'h008, "R7 node status");
        do_write(12'h600, 32'h0000_0004);
        do_read(12'h600, "R7 chain cleared");
        do_read(12'h608, "R7 node kept");
        do_read(12'h000, "R6 summary via node");

        // R5: event and clear in the same cycle
        @(negedge clk);
        evt_err2 = 16'h0100; wr = 1'b1; addr = 12'h618; wdata = 32'h0000_0100;
        @(negedge clk);
        evt_err2 = '0; wr = 1'b0;
        m_raw[3] |= 16'h0100;
        do_read(12'h618, "R5 event beats clear");

        // R9: writes to status words are ignored, unmapped reads give zero
        do_write(12'h000, 32'hFFFF_FFFF);
        do_write(12'h004, 32'hFFFF_FFFF);
        do_write(12'h010, 32'hFFFF_FFFF);
        do_read(12'h020, "R9 err1 mask unchanged");
        do_read(12'h608, "R9 node raw unchanged");
        do_read(12'h014, "R9 unmapped gap");
        do_read(12'h604, "R9 unmapped raw gap");

        // R10: back-to-back reads
        @(negedge clk);
        exp_q.push_back(model_read(12'h608)); tag_q.push_back("R10 first of pair");
        rd = 1'b1; addr = 12'h608;
        @(negedge clk);
        exp_q.push_back(model_read(12'h610)); tag_q.push_back("R10 second of pair");
        addr = 12'h610;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        check("R10 rvalid low when idle", {31'h0, rvalid}, 32'h0);

        // R8: clear everything, interrupt drops
        do_write(12'h020, 32'h0000_8000);
        do_write(12'h024, 32'h0000_0100);
        do_read(12'h000, "R6 summary with errors");
        for (int c = 0; c < 4; c++) do_write(12'(12'h600 + 8 * c), 32'h0000_FFFF);
        check("R8 irq after full clear", {31'h0, irq}, 32'h0);
        do_read(12'h000, "R6 summary cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R10 missing responses", 32'(exp_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule